// File: doc/BRIEF.md
# Cartridge Streaming Data Window

This block sits on the cartridge side of a host bus. An upstream controller feeds it a stream of 32-bit words that are grouped into 512-byte packets. The host sees the stream through a small memory-mapped window. The host first writes a byte count into a request register. The block then fills an eight-word buffer from the stream and raises a level interrupt when those 32 bytes are ready.

The host reads the eight words and then writes a one to the ready bit of the status register. That write clears the interrupt and lets the next fill begin. When the request runs out part way through a block, the rest of that block is filled with zeros. Every bus cycle is decoded from the address, chip-select and strobes on that cycle. A chip-select held high across a burst of reads is therefore treated as a series of separate accesses.

On the upstream side there is a four-phase packet handshake. The block takes words only while `pkt_avail` is high and its own `pkt_ack` is low. It raises `pkt_ack` once the last of the 128 words of a packet has been consumed. It holds `pkt_ack` until `pkt_avail` falls.

Top module: `cart_stream_window`

## Requirements
- R1: With the default base 0xDFFFC0, data word i of the window (i = 0..7) reads at base + 4*i, the status register at base + 0x20 and the request register at base + 0x24. Read data appears on `bus_rdata` one cycle after the cycle in which `bus_cs` and `bus_rd` are sampled high, and is zero when the read hits none of these addresses.
- R2: When `bus_cs` and `bus_rd` stay high over consecutive cycles while the address steps through the window, each cycle's address returns its own word one cycle later.
- R3: Stream byte n of a request lands in window word (n mod 32)/4, in bits 8*(n mod 4)+7 down to 8*(n mod 4). Word i of a block carries the i-th upstream word taken for that block.
- R4: `host_irq` is high exactly while a block is ready. Once a block is ready it stays ready until it is acknowledged. Status bit 0 reads the ready flag. Status bit 1 reads 1 while a packet is being drawn, meaning `pkt_avail` is high and `pkt_ack` is low.
- R5: A write to the status register with data bit 0 set clears the ready flag, so `host_irq` is low on the next cycle, and the next block fill starts. A status write with bit 0 clear changes nothing.
- R6: Filling stops once the requested number of bytes has been taken. Bytes past the count inside the last word read as zero, and words past the count in the last block read as zero. A request of N bytes yields ceil(N/32) interrupts.
- R7: A write to the request register is accepted only when the block is idle: no bytes remain, no block is ready and no fill is in progress. Any other such write is ignored. Reading the request register returns the bytes still to be taken.
- R8: While a block is ready, `up_ready` stays low and no upstream word is taken.
- R9: After the 128th word of a packet is taken, `pkt_ack` rises and stays high until `pkt_avail` is low. No word is taken while `pkt_ack` is high or `pkt_avail` is low. An unfinished packet carries over into the next request.
- R10: While `rst` is high at a clock edge, the ready flag, `host_irq`, `pkt_ack`, the remaining count and all window words go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs | input | 1 | Cartridge space select, sampled each cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| host_irq | output | 1 | Level interrupt: block ready |
| pkt_avail | input | 1 | Upstream packet available |
| pkt_ack | output | 1 | Packet consumed |
| up_valid | input | 1 | Upstream word valid |
| up_data | input | 32 | Upstream word |
| up_ready | output | 1 | Block takes the word this cycle |

## Verification
The assertions take three things for granted about the inputs. `pkt_avail` is dropped only after `pkt_ack` is seen. Bus strobes are valid at every rising edge. Reset is applied from time zero. The upstream model in the bench lowers `pkt_avail` one edge after it sees `pkt_ack`, waits a few cycles and raises it again for the next packet. It keeps `up_valid` tied to `pkt_avail`. All bus stimulus is driven on the falling edge, so the strobes are settled when the block samples them.

// File: rtl/cart_stream_window.sv
module cart_stream_window #(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE = 24'hDFFFC0,
  parameter int WIN_WORDS = 8,
  parameter int PKT_WORDS = 128,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              host_irq,
  input  logic              pkt_avail,
  output logic              pkt_ack,
  input  logic              up_valid,
  input  logic [31:0]       up_data,
  output logic              up_ready
);
  localparam int IDX_W = $clog2(WIN_WORDS);
  localparam int PKT_W = $clog2(PKT_WORDS);
  localparam int WIN_BYTES = WIN_WORDS * 4;
  localparam logic [ADDR_W-1:0] STAT_ADDR = BASE + ADDR_W'(WIN_BYTES);
  localparam logic [ADDR_W-1:0] REQ_ADDR  = STAT_ADDR + ADDR_W'(4);

  logic [31:0]      win [WIN_WORDS];
  logic [IDX_W-1:0] fidx;
  logic [CNT_W-1:0] rem;
  logic [PKT_W-1:0] pcnt;
  logic             ready;

  wire unused_bits = &{1'b0, bus_addr[1:0], bus_wdata[31:CNT_W]};

  wire win_hit  = bus_cs && (bus_addr[ADDR_W-1:IDX_W+2] == BASE[ADDR_W-1:IDX_W+2]);
  wire stat_hit = bus_cs && (bus_addr[ADDR_W-1:2] == STAT_ADDR[ADDR_W-1:2]);
  wire req_hit  = bus_cs && (bus_addr[ADDR_W-1:2] == REQ_ADDR[ADDR_W-1:2]);

  wire filling  = !ready && (rem != '0 || fidx != '0);
  wire idle     = !ready && rem == '0 && fidx == '0;
  wire pkt_live = pkt_avail && !pkt_ack;
  wire need     = filling && rem != '0;
  wire pad      = filling && rem == '0;
  wire take     = need && pkt_live && up_valid;
  wire ack_wr   = bus_wr && stat_hit && bus_wdata[0];
  wire req_wr   = bus_wr && req_hit && idle;

  assign up_ready = need && pkt_live;
  assign host_irq = ready;

  logic [31:0] keep;
  always_comb begin
    case (rem)
      CNT_W'(1): keep = 32'h0000_00FF;
      CNT_W'(2): keep = 32'h0000_FFFF;
      CNT_W'(3): keep = 32'h00FF_FFFF;
      default:   keep = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fidx  <= '0;
      rem   <= '0;
      ready <= 1'b0;
    end else begin
      if (take) rem <= (rem >= CNT_W'(4)) ? rem - CNT_W'(4) : '0;
      else if (req_wr) rem <= bus_wdata[CNT_W-1:0];
      if (take || pad) begin
        fidx <= fidx + 1'b1;
        if (fidx == IDX_W'(WIN_WORDS - 1)) ready <= 1'b1;
      end
      if (ack_wr) ready <= 1'b0;
    end
  end

  for (genvar i = 0; i < WIN_WORDS; i++) begin : g_win
    always_ff @(posedge clk) begin
      if (rst) win[i] <= '0;
      else if ((take || pad) && fidx == IDX_W'(i)) win[i] <= take ? (up_data & keep) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt    <= '0;
      pkt_ack <= 1'b0;
    end else begin
      if (take) begin
        pcnt <= pcnt + 1'b1;
        if (pcnt == PKT_W'(PKT_WORDS - 1)) pkt_ack <= 1'b1;
      end
      if (pkt_ack && !pkt_avail) pkt_ack <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd && stat_hit) bus_rdata <= {30'd0, pkt_live, ready};
    else if (bus_rd && req_hit) bus_rdata <= 32'(rem);
    else if (bus_rd && win_hit) bus_rdata <= win[bus_addr[IDX_W+1:2]];
    else bus_rdata <= '0;
  end

  assert_irq_drops_on_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && ready) |=> !host_irq);
  assert_ready_held_R4: assert property (@(posedge clk) disable iff (rst)
    (host_irq && !ack_wr) |=> host_irq);
  assert_no_take_while_ready_R8: assert property (@(posedge clk) disable iff (rst)
    host_irq |-> !up_ready);
  assert_pkt_ack_held_R9: assert property (@(posedge clk) disable iff (rst)
    (pkt_ack && pkt_avail) |=> pkt_ack);
  assert_pkt_ack_on_boundary_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_ack) |-> pcnt == '0);
  assert_rem_no_grow_R7: assert property (@(posedge clk) disable iff (rst)
    !req_wr |=> rem <= $past(rem));
  assert_pad_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (pad && fidx == '0) |=> win[0] == '0);
endmodule

// File: tb/cart_stream_window_tb.sv
module cart_stream_window_tb;
  localparam logic [23:0] BASE = 24'hDFFFC0;
  localparam logic [23:0] STAT = BASE + 24'h20;
  localparam logic [23:0] REQ  = BASE + 24'h24;
  localparam int NV = 6;
  localparam int VEC [NV][2] = '{'{64, 2}, '{45, 2}, '{7, 1}, '{32, 1}, '{3, 1}, '{100, 4}};

  logic clk = 0, rst = 1;
  logic bus_cs = 0, bus_rd = 0, bus_wr = 0;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, up_data;
  logic host_irq, pkt_ack, up_ready, pkt_avail, up_valid;
  int widx, gap, pkts, ack_widx, viol9, viol8, gw;
  int tests = 0, fails = 0;
  logic prev_ack;

  always #2 clk = ~clk;

  cart_stream_window u_dut (.clk, .rst, .bus_cs, .bus_rd, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata, .host_irq, .pkt_avail, .pkt_ack, .up_valid, .up_data, .up_ready);

  function automatic logic [31:0] mk(int w);
    return {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)};
  endfunction
  function automatic logic [31:0] exp_word(int cnt, int g0, int off);
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++)
      if (off + j < cnt) r[8*j +: 8] = 8'((g0 + off/4)*4 + j);
    return r;
  endfunction

  assign up_valid = pkt_avail;
  assign up_data = mk(widx);

  always @(posedge clk) begin
    if (rst) begin
      pkt_avail <= 0; gap <= 2; widx <= 0;
    end else begin
      if (up_valid && up_ready) widx <= widx + 1;
      if (!pkt_avail) begin
        if (gap == 0) pkt_avail <= 1; else gap <= gap - 1;
      end else if (pkt_ack) begin
        pkt_avail <= 0; gap <= 3; pkts <= pkts + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (up_ready && (!pkt_avail || pkt_ack)) viol9++;
      if (host_irq && up_ready) viol8++;
      if (pkt_ack && !prev_ack) ack_widx = widx;
    end
    prev_ack = pkt_ack;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [23:0] a, logic [31:0] d);
    @(negedge clk); bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_cs = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [23:0] a, output logic [31:0] d);
    @(negedge clk); bus_cs = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_cs = 0; bus_rd = 0;
  endtask

  task automatic wait_irq(string tag);
    int n = 0;
    while (!host_irq && n < 3000) begin @(negedge clk); n++; end
    chk(host_irq, tag, 32'(host_irq), 1);
  endtask

  task automatic run_req(int cnt, int blocks, string tag);
    logic [31:0] d;
    wr(REQ, 32'(cnt));
    for (int b = 0; b < blocks; b++) begin
      wait_irq({tag, " R4 irq"});
      for (int i = 0; i < 8; i++) begin
        rd(BASE + 24'(4*i), d);
        chk(d == exp_word(cnt, gw, 32*b + 4*i), {tag, " R3/R6 data"}, d, exp_word(cnt, gw, 32*b + 4*i));
      end
      wr(STAT, 1);
      chk(!host_irq, {tag, " R5 irq drop"}, 32'(host_irq), 0);
    end
    repeat (40) @(negedge clk);
    chk(!host_irq, {tag, " R6 block count"}, 32'(host_irq), 0);
    rd(REQ, d);
    chk(d == 0, {tag, " R7 remaining"}, d, 0);
    gw += (cnt + 3) / 4;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    pkts = 0; viol9 = 0; viol8 = 0; gw = 0; ack_widx = -1; prev_ack = 0;
    repeat (3) @(negedge clk);
    chk(!host_irq && !pkt_ack, "R10 reset outputs", {30'd0, host_irq, pkt_ack}, 0);
    rst = 0;
    rd(STAT, d); chk(d[0] == 0, "R10 status ready", d, 0);
    rd(REQ, d);  chk(d == 0, "R10 remaining", d, 0);
    rd(BASE + 24'h1C, d); chk(d == 0, "R10 window empty", d, 0);
    rd(24'hDFFF80, d); chk(d == 0, "R1 miss reads zero", d, 0);

    for (int v = 0; v < NV; v++) run_req(VEC[v][0], VEC[v][1], $sformatf("vec%0d", v));

    wr(REQ, 32);
    wait_irq("R4 burst block");
    rd(STAT, d); chk(d[0] == 1, "R4 status ready bit", d, 1);
    chk(up_ready == 0, "R8 up_ready low while ready", 32'(up_ready), 0);
    wr(REQ, 999);
    rd(REQ, d); chk(d == 0, "R7 request ignored while busy", d, 0);
    wr(STAT, 0);
    chk(host_irq, "R5 zero write no effect", 32'(host_irq), 1);
    @(negedge clk);
    bus_cs = 1; bus_rd = 1; bus_addr = BASE;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      d = bus_rdata;
      if (k < 8) bus_addr = BASE + 24'(4*k); else begin bus_rd = 0; bus_cs = 0; end
      chk(d == mk(gw + k - 1), "R2 burst word", d, mk(gw + k - 1));
    end
    wr(STAT, 1);
    gw += 8;

    run_req(512, 16, "R9 full packet");
    chk(pkts == 1, "R9 one packet acked", 32'(pkts), 1);
    chk(ack_widx == 128, "R9 ack after 128 words", 32'(ack_widx), 128);
    chk(viol9 == 0, "R9 no take during ack", 32'(viol9), 0);
    chk(viol8 == 0, "R8 no take while ready", 32'(viol8), 0);

    rd(STAT, d); chk(d[1] == (pkt_avail && !pkt_ack), "R4 status packet bit", d, {30'd0, pkt_avail && !pkt_ack, 1'b0});

    wr(REQ, 8);
    wait_irq("R10 pre-reset ready");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk(!host_irq && !pkt_ack, "R10 mid-run reset", {30'd0, host_irq, pkt_ack}, 0);
    rd(BASE, d); chk(d == 0, "R10 window cleared", d, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule